// File: doc/BRIEF.md
# Pipelined Wide Leading-One Locator

This block measures the significant length of a wide bit vector: how many bits are left once every leading zero is removed. This count is equal to the position of the highest set bit plus one. An all-zero vector has a length of zero, and a separate flag marks that case.

The vector is divided into 16-bit segments. In the first clock, every segment finds its own highest set bit in parallel, and the per-segment results are registered. In the second clock, a balanced selection tree picks the highest segment that holds a set bit and converts its local position into the final length. Logic depth therefore grows with the logarithm of the width, not linearly. The block takes a new vector on every cycle, and each result appears exactly two cycles after its input.

Top module: `lead_len`

## Requirements
- R1: For a valid input, `out_len` equals the index of the highest set bit plus one (low byte 0x1A with all other bits clear gives 5; bit 0 alone gives 1).
- R2: An all-zero valid input gives `out_len` = 0 and `out_zero` = 1.
- R3: Whenever any input bit is set, `out_zero` is 0 for that result.
- R4: `out_vld` is high exactly two clock cycles after `in_vld` was high, and that result belongs to the input sampled with it.
- R5: Inputs presented on consecutive cycles each produce their own result on consecutive cycles, in input order.
- R6: With the top bit (index W-1) set, `out_len` equals W (1024 at the default width); the output width is ceil(log2(W+1)) bits.
- R7: Set bits below the highest one have no effect on the result, even when they sit in other segments.
- R8: Results are correct across segment boundaries: highest bit 15 gives 16, highest bit 16 gives 17.
- R9: While `rst_n` is low at a clock edge, the next state has `out_vld`, `out_len` and `out_zero` all at 0.
- R10: A cycle with `in_vld` low yields `out_vld` low two cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | Input vector is valid this cycle |
| in_data | input | W | Vector to measure |
| out_vld | output | 1 | Result valid |
| out_len | output | ceil(log2(W+1)) | Significant length |
| out_zero | output | 1 | Result came from an all-zero vector |

## Verification
Two things can happen in the same cycle: a result leaves the merge stage while a new vector enters the segment stage. Back-to-back streaming is therefore the main stress case. The bench drives a table of vectors on consecutive cycles, and some of them set bits in several segments or on a segment boundary. Each output cycle is compared against the table entry issued two cycles before. Any sharing or staleness between neighbouring vectors shows up as a length that belongs to the wrong entry.

// File: rtl/lead_pkg.sv
// Package: shared constants for the leading-one locator.
// Assumes the input width is a multiple of SEG_W.
package lead_pkg;
    localparam int SEG_W = 16;
    localparam int LOC_W = $clog2(SEG_W);

    // Width needed to hold a length from 0 up to w inclusive.
    function automatic int len_bits(input int w);
        return $clog2(w + 1);
    endfunction
endpackage

// File: rtl/prio_tree.sv
// prio_tree: balanced tree that returns the value carried by the
// highest-numbered leaf whose flag is set. Depth is ceil(log2(N)).
// Assumes N >= 1; unused padding leaves are tied empty.
module prio_tree #(
    parameter int N  = 16,
    parameter int VW = 4
) (
    input  logic [N-1:0]         leaf_ok,
    input  logic [N-1:0][VW-1:0] leaf_val,
    output logic                 any,
    output logic [VW-1:0]        val
);
    localparam int LV = (N > 1) ? $clog2(N) : 0;
    localparam int NP = 1 << LV;

    // Heap layout: node k has children 2k and 2k+1, leaves at NP..2NP-1.
    logic          node_ok  [1:2*NP-1];
    logic [VW-1:0] node_val [1:2*NP-1];

    genvar g;
    generate
        for (g = 0; g < NP; g++) begin : g_leaf
            if (g < N) begin : g_real
                assign node_ok[NP+g]  = leaf_ok[g];
                assign node_val[NP+g] = leaf_val[g];
            end else begin : g_pad
                assign node_ok[NP+g]  = 1'b0;
                assign node_val[NP+g] = '0;
            end
        end
        for (g = 1; g < NP; g++) begin : g_node
            // Upper child wins whenever it holds a set flag.
            assign node_ok[g]  = node_ok[2*g] | node_ok[2*g+1];
            assign node_val[g] = node_ok[2*g+1] ? node_val[2*g+1] : node_val[2*g];
        end
    endgenerate

    assign any = node_ok[1];
    assign val = node_val[1];
endmodule

// File: rtl/seg_stage.sv
// seg_stage: first pipeline stage. Each SEG_W-bit segment finds, in
// parallel, whether it holds a set bit and where its highest one is.
// Assumes W is a multiple of SEG_W.
module seg_stage
    import lead_pkg::*;
#(
    parameter int W = 1024
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_vld,
    input  logic [W-1:0]                 in_data,
    output logic                         s1_vld,
    output logic [W/SEG_W-1:0]           s1_hit,
    output logic [W/SEG_W-1:0][LOC_W-1:0] s1_loc
);
    localparam int NSEG = W / SEG_W;

    logic [NSEG-1:0]            hit_c;
    logic [NSEG-1:0][LOC_W-1:0] loc_c;

    genvar s, b;
    generate
        for (s = 0; s < NSEG; s++) begin : g_seg
            logic [SEG_W-1:0]            seg;
            logic [SEG_W-1:0][LOC_W-1:0] idx;
            assign seg = in_data[s*SEG_W +: SEG_W];
            for (b = 0; b < SEG_W; b++) begin : g_idx
                assign idx[b] = LOC_W'(b);
            end
            prio_tree #(.N(SEG_W), .VW(LOC_W)) u_scan (
                .leaf_ok (seg),
                .leaf_val(idx),
                .any     (hit_c[s]),
                .val     (loc_c[s])
            );
            // Guard: the reported bit is set and nothing above it is (R8).
            always_comb begin
                if (hit_c[s]) begin
                    p_seg_top_r8: assert ((seg >> loc_c[s]) == SEG_W'(1));
                end
            end
        end
    endgenerate

    // Register the per-segment findings and the valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld <= 1'b0;
            s1_hit <= '0;
            s1_loc <= '0;
        end else begin
            s1_vld <= in_vld;
            s1_hit <= hit_c;
            s1_loc <= loc_c;
        end
    end
endmodule

// File: rtl/merge_stage.sv
// merge_stage: second pipeline stage. Picks the highest segment with a
// set bit and turns segment number plus local position into a length.
// Assumes inputs come straight from seg_stage registers.
module merge_stage
    import lead_pkg::*;
#(
    parameter int W  = 1024,
    parameter int LW = 11
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          s1_vld,
    input  logic [W/SEG_W-1:0]            s1_hit,
    input  logic [W/SEG_W-1:0][LOC_W-1:0] s1_loc,
    output logic                          out_vld,
    output logic [LW-1:0]                 out_len,
    output logic                          out_zero
);
    localparam int NSEG = W / SEG_W;

    logic [NSEG-1:0][LW-1:0] cand;
    logic                    found;
    logic [LW-1:0]           best;

    genvar s;
    generate
        for (s = 0; s < NSEG; s++) begin : g_cand
            // Length if this segment turns out to be the highest non-empty one.
            assign cand[s] = LW'(s * SEG_W + 1) + {{(LW-LOC_W){1'b0}}, s1_loc[s]};
        end
    endgenerate

    prio_tree #(.N(NSEG), .VW(LW)) u_pick (
        .leaf_ok (s1_hit),
        .leaf_val(cand),
        .any     (found),
        .val     (best)
    );

    // Register the final length, zero flag and valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_len  <= '0;
            out_zero <= 1'b0;
        end else begin
            out_vld  <= s1_vld;
            out_len  <= found ? best : '0;
            out_zero <= ~found;
        end
    end
endmodule

// File: rtl/lead_len.sv
// lead_len: two-stage significant-length finder for a wide vector.
// Stage 1 scans segments in parallel, stage 2 merges them by a tree.
// Assumes W is a multiple of 16; accepts one vector per cycle.
module lead_len
    import lead_pkg::*;
#(
    parameter int W  = 1024,
    parameter int LW = len_bits(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [W-1:0]  in_data,
    output logic          out_vld,
    output logic [LW-1:0] out_len,
    output logic          out_zero
);
    localparam int NSEG = W / SEG_W;

    logic                         s1_vld;
    logic [NSEG-1:0]              s1_hit;
    logic [NSEG-1:0][LOC_W-1:0]   s1_loc;

    seg_stage #(.W(W)) u_seg (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_vld (in_vld),
        .in_data(in_data),
        .s1_vld (s1_vld),
        .s1_hit (s1_hit),
        .s1_loc (s1_loc)
    );

    merge_stage #(.W(W), .LW(LW)) u_merge (
        .clk     (clk),
        .rst_n   (rst_n),
        .s1_vld  (s1_vld),
        .s1_hit  (s1_hit),
        .s1_loc  (s1_loc),
        .out_vld (out_vld),
        .out_len (out_len),
        .out_zero(out_zero)
    );

    // Valid moves one stage per cycle (R4).
    p_stage1_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (s1_vld == $past(in_vld)));
    p_stage2_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_vld == $past(s1_vld)));
    // Zero flag and length agree (R2, R3).
    p_zero_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (out_zero == (out_len == '0)));
    // Length never exceeds the width (R6).
    p_len_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (out_len <= LW'(W)));
endmodule

// File: tb/sim_lead_len.sv
module sim_lead_len;
    localparam int W   = 1024;
    localparam int LW  = 11;
    localparam int CLK = 10;
    localparam int N   = 10;

    // Table: highest set bit, one extra lower bit (-1 = none), expected length.
    localparam int HI  [N] = '{4, -1, 1023, 0, 15, 16, 500, 1008, 63, 1022};
    localparam int LO  [N] = '{1, -1, 0, -1, 3, 15, 200, 1007, -1, 5};
    localparam int EXP [N] = '{5, 0, 1024, 1, 16, 17, 501, 1009, 64, 1023};
    localparam string TAG [N] = '{"R1", "R2", "R6", "R1", "R8", "R8", "R7", "R7", "R5", "R7"};

    logic          clk = 0;
    logic          rst_n = 0;
    logic          in_vld = 0;
    logic [W-1:0]  in_data = '0;
    logic          out_vld;
    logic [LW-1:0] out_len;
    logic          out_zero;

    int total = 0;
    int bad = 0;

    always #(CLK/2) clk = ~clk;

    lead_len #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data),
        .out_vld(out_vld), .out_len(out_len), .out_zero(out_zero)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] make_vec(input int hi, input int lo);
        logic [W-1:0] v = '0;
        if (hi >= 0) v[hi] = 1'b1;
        if (lo >= 0) v[lo] = 1'b1;
        return v;
    endfunction

    task automatic check_result(input string req, input int exp);
        chk(out_vld == 1'b1, req, out_vld, 1);
        chk(out_len == LW'(exp), req, out_len, exp);
        chk(out_zero == (exp == 0), req, out_zero, (exp == 0));
    endtask

    // Drive one vector alone and check it two cycles later.
    task automatic single(input logic [W-1:0] v, input string req, input int exp);
        @(negedge clk); in_vld = 1; in_data = v;
        @(negedge clk); in_vld = 0; in_data = '0;
        @(negedge clk); check_result(req, exp);
    endtask

    initial begin
        #(CLK * 100000);
        chk(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // Reset state (R9).
        repeat (3) @(negedge clk);
        chk(out_vld == 0, "R9", out_vld, 0);
        chk(out_len == 0, "R9", out_len, 0);
        chk(out_zero == 0, "R9", out_zero, 0);
        rst_n = 1;

        // Back-to-back table stream (R5, R4 and per-entry requirement).
        for (int i = 0; i < N + 2; i++) begin
            @(negedge clk);
            if (i >= 2) check_result(TAG[i-2], EXP[i-2]);
            if (i < N) begin
                in_vld = 1; in_data = make_vec(HI[i], LO[i]);
            end else begin
                in_vld = 0; in_data = '0;
            end
        end

        // Bubble: invalid cycles give no valid output (R10).
        @(negedge clk);
        chk(out_vld == 0, "R10", out_vld, 0);
        @(negedge clk);
        chk(out_vld == 0, "R10", out_vld, 0);

        // Exact latency: not early after one cycle (R4).
        @(negedge clk); in_vld = 1; in_data = make_vec(700, -1);
        @(negedge clk); in_vld = 0; in_data = '0;
        chk(out_vld == 0, "R4", out_vld, 0);
        @(negedge clk);
        check_result("R4", 701);

        // Byte pattern 0x1A in the low byte (R1).
        single({{(W-8){1'b0}}, 8'h1A}, "R1", 5);
        // All ones (R6) and all zero (R2, R3).
        single('1, "R6", 1024);
        single('0, "R2", 0);
        single(make_vec(31, 2), "R3", 32);

        // Reset in mid-stream clears outputs (R9).
        @(negedge clk); in_vld = 1; in_data = make_vec(900, -1);
        @(negedge clk); in_data = make_vec(901, -1);
        rst_n = 0;
        @(negedge clk);
        chk(out_vld == 0, "R9", out_vld, 0);
        chk(out_len == 0, "R9", out_len, 0);
        chk(out_zero == 0, "R9", out_zero, 0);
        in_vld = 0; in_data = '0; rst_n = 1;
        @(negedge clk);
        @(negedge clk);
        chk(out_vld == 0, "R9", out_vld, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule